// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Encoder

This block merges the interrupt sources of one UART channel into a single identification code and an interrupt request line. Seven sources feed it: a receiver line error, a receive time-out, received data at threshold, transmit holding space, a modem status change, a received Xoff character and a change on the hardware flow-control lines. Five of them arrive as one-cycle event pulses and are held in pending flags inside the block. The time-out and received-data sources are levels that follow their conditions. Each source has its own enable bit. An enabled pending source takes part in arbitration, and the block reports the winner as a 6-bit code.

A small state machine holds the reported source. Each clock edge it moves from whatever state it is in to the state of the highest-priority enabled pending source, after the clears and sets of that cycle have been applied. The states are ST_NONE, ST_LINE, ST_TOUT, ST_RXD, ST_TXE, ST_MODEM, ST_XOFF and ST_FLOW. A read of the identification code clears the transmit, Xoff and flow-change sources, but only when that source is the one being reported. A read of the line status clears the line error. A read of the modem status clears the modem change.

Top module: `irq_ident_ctrl`

## Requirements
- R1: After reset, ident_code is 6'b000001 and irq is 0.
- R2: The reported codes are: none 6'b000001, line error 6'b000110, time-out 6'b001100, received data 6'b000100, transmit space 6'b000010, modem change 6'b000000, Xoff received 6'b010000, flow-line change 6'b100000. Bit 0 is 1 only when nothing is reported.
- R3: Priority from highest to lowest is line error, time-out, received data, transmit space, modem change, Xoff received, flow-line change.
- R4: src_en bit positions are 0 line, 1 time-out, 2 received data, 3 transmit, 4 modem, 5 Xoff, 6 flow-line. A source whose enable is 0 is never reported, but its pending flag is kept and is reported once the enable is set.
- R5: irq is 1 exactly when the reported code is not 6'b000001.
- R6: The line error flag is cleared by lsr_rd and not by ident_rd.
- R7: ident_rd clears the Xoff flag only while Xoff is the reported source. A read that reports another source leaves the flag pending.
- R8: ident_rd clears the transmit-space flag while it is the reported source.
- R9: ident_rd clears the flow-line change flag while it is the reported source.
- R10: The modem change flag is cleared by msr_rd.
- R11: The time-out and received-data sources follow lvl_tout and lvl_rxd and are not cleared by any read.
- R12: A set pulse in the same cycle as a clearing read leaves the flag pending.
- R13: A change at the inputs sampled at one clock edge shows up on ident_code and irq right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_line | input | 1 | Line error event pulse |
| set_thr | input | 1 | Transmit space event pulse |
| set_modem | input | 1 | Modem status change event pulse |
| set_xoff | input | 1 | Xoff received event pulse |
| set_flow | input | 1 | Flow-line change event pulse |
| lvl_tout | input | 1 | Receive time-out condition (level) |
| lvl_rxd | input | 1 | Received data at threshold (level) |
| src_en | input | 7 | Per-source enable bits |
| ident_rd | input | 1 | Identification code read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| ident_code | output | 6 | Code of the reported source |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the relation between irq and the idle code, the precedence of a new line error and an active time-out, the suppression of irq when every enable is low, and the clearing effect of each kind of read on the source it targets. Only the bench scenarios can show the full priority chain as sources are removed one by one, that a disabled flag is kept and later reported, that a read leaves a source pending when a different source is reported, and the behaviour under random mixes of events and reads compared against a reference model.

// File: rtl/irq_ident_pkg.sv
package irq_ident_pkg;
    localparam int SRC_N  = 7;
    localparam int CODE_W = 6;

    localparam int SRC_LINE  = 0;
    localparam int SRC_TOUT  = 1;
    localparam int SRC_RXD   = 2;
    localparam int SRC_TXE   = 3;
    localparam int SRC_MODEM = 4;
    localparam int SRC_XOFF  = 5;
    localparam int SRC_FLOW  = 6;

    localparam logic [CODE_W-1:0] C_NONE  = 6'b000001;
    localparam logic [CODE_W-1:0] C_LINE  = 6'b000110;
    localparam logic [CODE_W-1:0] C_TOUT  = 6'b001100;
    localparam logic [CODE_W-1:0] C_RXD   = 6'b000100;
    localparam logic [CODE_W-1:0] C_TXE   = 6'b000010;
    localparam logic [CODE_W-1:0] C_MODEM = 6'b000000;
    localparam logic [CODE_W-1:0] C_XOFF  = 6'b010000;
    localparam logic [CODE_W-1:0] C_FLOW  = 6'b100000;

    // State value k (k>0) stands for source index k-1
    typedef enum logic [2:0] {
        ST_NONE  = 3'd0,
        ST_LINE  = 3'd1,
        ST_TOUT  = 3'd2,
        ST_RXD   = 3'd3,
        ST_TXE   = 3'd4,
        ST_MODEM = 3'd5,
        ST_XOFF  = 3'd6,
        ST_FLOW  = 3'd7
    } rep_state_t;
endpackage

// File: rtl/irq_flag_latch.sv
module irq_flag_latch #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_nxt_o
);
    logic [W-1:0] pend_q;

    for (genvar i = 0; i < W; i++) begin : g_flag
        // a set in the same cycle as a clear wins
        assign pend_nxt_o[i] = set_i[i] | (pend_q[i] & ~clr_i[i]);

        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[i] <= 1'b0;
            else        pend_q[i] <= pend_nxt_o[i];
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_ident_pkg::*;
(
    input  logic [SRC_N-1:0] req_i,
    output rep_state_t       pick_o
);
    always_comb begin
        pick_o = ST_NONE;
        // scan from lowest priority up so the highest one is written last
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (req_i[i]) pick_o = rep_state_t'(3'(i + 1));
        end
    end
endmodule

// File: rtl/irq_ident_ctrl.sv
module irq_ident_ctrl
    import irq_ident_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_line,
    input  logic              set_thr,
    input  logic              set_modem,
    input  logic              set_xoff,
    input  logic              set_flow,
    input  logic              lvl_tout,
    input  logic              lvl_rxd,
    input  logic [SRC_N-1:0]  src_en,
    input  logic              ident_rd,
    input  logic              lsr_rd,
    input  logic              msr_rd,
    output logic [CODE_W-1:0] ident_code,
    output logic              irq
);
    rep_state_t       state_q;
    rep_state_t       state_nxt;
    logic [SRC_N-1:0] ev_set;
    logic [SRC_N-1:0] ev_clr;
    logic [SRC_N-1:0] held_nxt;
    logic [SRC_N-1:0] lvl_vec;
    logic [SRC_N-1:0] req;

    always_comb begin
        ev_set            = '0;
        ev_set[SRC_LINE]  = set_line;
        ev_set[SRC_TXE]   = set_thr;
        ev_set[SRC_MODEM] = set_modem;
        ev_set[SRC_XOFF]  = set_xoff;
        ev_set[SRC_FLOW]  = set_flow;

        ev_clr            = '0;
        ev_clr[SRC_LINE]  = lsr_rd;
        ev_clr[SRC_MODEM] = msr_rd;
        ev_clr[SRC_TXE]   = ident_rd && (state_q == ST_TXE);
        ev_clr[SRC_XOFF]  = ident_rd && (state_q == ST_XOFF);
        ev_clr[SRC_FLOW]  = ident_rd && (state_q == ST_FLOW);

        lvl_vec           = '0;
        lvl_vec[SRC_TOUT] = lvl_tout;
        lvl_vec[SRC_RXD]  = lvl_rxd;
    end

    irq_flag_latch #(.W(SRC_N)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (ev_set),
        .clr_i      (ev_clr),
        .pend_nxt_o (held_nxt)
    );

    assign req = (held_nxt | lvl_vec) & src_en;

    irq_prio_pick u_pick (
        .req_i  (req),
        .pick_o (state_nxt)
    );

    // state register: every state moves to the current winner
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NONE;
        else        state_q <= state_nxt;
    end

    // outputs from state
    always_comb begin
        irq = 1'b1;
        unique case (state_q)
            ST_NONE:  begin ident_code = C_NONE; irq = 1'b0; end
            ST_LINE:  ident_code = C_LINE;
            ST_TOUT:  ident_code = C_TOUT;
            ST_RXD:   ident_code = C_RXD;
            ST_TXE:   ident_code = C_TXE;
            ST_MODEM: ident_code = C_MODEM;
            ST_XOFF:  ident_code = C_XOFF;
            ST_FLOW:  ident_code = C_FLOW;
            default:  begin ident_code = C_NONE; irq = 1'b0; end
        endcase
    end
endmodule

// File: rtl/irq_ident_chk.sv
module irq_ident_chk
    import irq_ident_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              set_line,
    input logic              set_thr,
    input logic              set_modem,
    input logic              set_xoff,
    input logic              set_flow,
    input logic              lvl_tout,
    input logic [SRC_N-1:0]  src_en,
    input logic              ident_rd,
    input logic              lsr_rd,
    input logic              msr_rd,
    input logic [CODE_W-1:0] ident_code,
    input logic              irq
);
    a_r5_irq_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (ident_code != C_NONE));

    a_r3_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_line && src_en[SRC_LINE]) |=> (ident_code == C_LINE));

    a_r3_tout_over_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_tout && src_en[SRC_TOUT]) |=> (ident_code == C_LINE || ident_code == C_TOUT));

    a_r4_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == '0) |=> !irq);

    a_r6_lsr_clears_line: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !set_line) |=> (ident_code != C_LINE));

    a_r7_xoff_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ident_rd && ident_code == C_XOFF && !set_xoff) |=> (ident_code != C_XOFF));

    a_r8_txe_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ident_rd && ident_code == C_TXE && !set_thr) |=> (ident_code != C_TXE));

    a_r9_flow_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ident_rd && ident_code == C_FLOW && !set_flow) |=> (ident_code != C_FLOW));

    a_r10_msr_clears_modem: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !set_modem) |=> (ident_code != C_MODEM || !irq));

    a_r2_code_shape: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ident_code) <= 2);
endmodule

bind irq_ident_ctrl irq_ident_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_line   (set_line),
    .set_thr    (set_thr),
    .set_modem  (set_modem),
    .set_xoff   (set_xoff),
    .set_flow   (set_flow),
    .lvl_tout   (lvl_tout),
    .src_en     (src_en),
    .ident_rd   (ident_rd),
    .lsr_rd     (lsr_rd),
    .msr_rd     (msr_rd),
    .ident_code (ident_code),
    .irq        (irq)
);

// File: tb/sim_irq_ident_ctrl.sv
module sim_irq_ident_ctrl;
    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] K_NONE  = 6'b000001;
    localparam logic [5:0] K_LINE  = 6'b000110;
    localparam logic [5:0] K_TOUT  = 6'b001100;
    localparam logic [5:0] K_RXD   = 6'b000100;
    localparam logic [5:0] K_TXE   = 6'b000010;
    localparam logic [5:0] K_MODEM = 6'b000000;
    localparam logic [5:0] K_XOFF  = 6'b010000;
    localparam logic [5:0] K_FLOW  = 6'b100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_line = 0, s_thr = 0, s_modem = 0, s_xoff = 0, s_flow = 0;
    logic       l_tout = 0, l_rxd = 0;
    logic [6:0] en = 7'h7f;
    logic       rd_id = 0, rd_lsr = 0, rd_msr = 0;
    logic [5:0] code;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic m_line = 0, m_thr = 0, m_modem = 0, m_xoff = 0, m_flow = 0;
    logic [5:0] m_code = K_NONE;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_ident_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .set_line(s_line), .set_thr(s_thr), .set_modem(s_modem),
        .set_xoff(s_xoff), .set_flow(s_flow),
        .lvl_tout(l_tout), .lvl_rxd(l_rxd), .src_en(en),
        .ident_rd(rd_id), .lsr_rd(rd_lsr), .msr_rd(rd_msr),
        .ident_code(code), .irq(irq)
    );

    function automatic logic [5:0] pick_code();
        if (m_line  && en[0]) return K_LINE;
        if (l_tout  && en[1]) return K_TOUT;
        if (l_rxd   && en[2]) return K_RXD;
        if (m_thr   && en[3]) return K_TXE;
        if (m_modem && en[4]) return K_MODEM;
        if (m_xoff  && en[5]) return K_XOFF;
        if (m_flow  && en[6]) return K_FLOW;
        return K_NONE;
    endfunction

    task automatic check(string tag, logic [5:0] got, logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // one clock: model update at the edge, compare between edges
    task automatic tick(string tag);
        @(posedge clk);
        m_line  = s_line  | (m_line  & ~rd_lsr);
        m_modem = s_modem | (m_modem & ~rd_msr);
        m_thr   = s_thr   | (m_thr   & ~(rd_id && m_code == K_TXE));
        m_xoff  = s_xoff  | (m_xoff  & ~(rd_id && m_code == K_XOFF));
        m_flow  = s_flow  | (m_flow  & ~(rd_id && m_code == K_FLOW));
        m_code  = pick_code();
        @(negedge clk);
        check(tag, code, m_code);
        check({tag, " irq"}, {5'b0, irq}, {5'b0, m_code != K_NONE});
        {s_line, s_thr, s_modem, s_xoff, s_flow} = '0;
        {rd_id, rd_lsr, rd_msr} = '0;
    endtask

    task automatic t_reset();
        check("R1 code", code, K_NONE);
        check("R1 irq", {5'b0, irq}, 6'b0);
    endtask

    task automatic t_each_alone();
        s_line = 1;  tick("R13 line");   check("R2 line", code, K_LINE);
        rd_lsr = 1;  tick("R6 lsr");     check("R6 cleared", code, K_NONE);
        l_tout = 1;  tick("R11 tout");   check("R2 tout", code, K_TOUT);
        l_tout = 0;  l_rxd = 1; tick("R11 rxd"); check("R2 rxd", code, K_RXD);
        l_rxd = 0;   tick("R11 low");
        s_thr = 1;   tick("R8 set");     check("R2 txe", code, K_TXE);
        rd_id = 1;   tick("R8 read");    check("R8 cleared", code, K_NONE);
        s_modem = 1; tick("R10 set");    check("R2 modem", code, K_MODEM);
        check("R5 modem irq", {5'b0, irq}, 6'b1);
        rd_msr = 1;  tick("R10 read");   check("R10 cleared", code, K_NONE);
        s_xoff = 1;  tick("R7 set");     check("R2 xoff", code, K_XOFF);
        rd_id = 1;   tick("R7 read");
        s_flow = 1;  tick("R9 set");     check("R2 flow", code, K_FLOW);
        rd_id = 1;   tick("R9 read");    check("R9 cleared", code, K_NONE);
    endtask

    task automatic t_priority();
        s_line = 1; s_thr = 1; s_modem = 1; s_xoff = 1; s_flow = 1;
        l_tout = 1; l_rxd = 1;
        tick("R3 all");                  check("R3 top", code, K_LINE);
        rd_id = 1;  tick("R6 id no clr"); check("R6 kept", code, K_LINE);
        rd_lsr = 1; tick("R3 -> tout");  check("R3 tout", code, K_TOUT);
        rd_id = 1;  tick("R11 read");    check("R11 kept", code, K_TOUT);
        l_tout = 0; tick("R3 -> rxd");   check("R3 rxd", code, K_RXD);
        l_rxd = 0;  tick("R3 -> txe");   check("R3 txe", code, K_TXE);
        rd_id = 1;  tick("R3 -> modem"); check("R3 modem", code, K_MODEM);
        rd_msr = 1; tick("R3 -> xoff");  check("R3 xoff", code, K_XOFF);
        rd_id = 1;  tick("R3 -> flow");  check("R3 flow", code, K_FLOW);
        rd_id = 1;  tick("R3 -> none");  check("R3 none", code, K_NONE);
    endtask

    task automatic t_enable();
        en = 7'b0; s_xoff = 1; tick("R4 masked");
        check("R4 no irq", {5'b0, irq}, 6'b0);
        en = 7'b0100000; tick("R4 unmask"); check("R4 reported", code, K_XOFF);
        en = 7'h7f; rd_id = 1; tick("R4 clear");
    endtask

    task automatic t_xoff_other();
        s_xoff = 1; s_modem = 1; tick("R7 both");
        rd_id = 1;  tick("R7 other read"); check("R7 modem shown", code, K_MODEM);
        rd_msr = 1; tick("R7 still");       check("R7 xoff kept", code, K_XOFF);
        s_xoff = 1; rd_id = 1; tick("R12 set+clr"); check("R12 kept", code, K_XOFF);
        rd_id = 1;  tick("R7 final");       check("R7 gone", code, K_NONE);
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            s_line  = ($urandom % 8) == 0;
            s_thr   = ($urandom % 6) == 0;
            s_modem = ($urandom % 7) == 0;
            s_xoff  = ($urandom % 7) == 0;
            s_flow  = ($urandom % 7) == 0;
            l_tout  = ($urandom % 5) == 0;
            l_rxd   = ($urandom % 4) == 0;
            en      = 7'($urandom) | 7'($urandom);
            rd_id   = ($urandom % 2) == 0;
            rd_lsr  = ($urandom % 4) == 0;
            rd_msr  = ($urandom % 4) == 0;
            tick("R3 random");
        end
        l_tout = 0; l_rxd = 0; en = 7'h7f;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick("R1 idle");
        t_each_alone();
        t_priority();
        t_enable();
        t_xoff_other();
        t_random();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule